// File: doc/BRIEF.md
# Vector-to-Scalar Condition Mask Interlock

This block decides, for one wavefront, whether the decoded instruction at the head of its queue may issue in the current issue slot. A slot is four clock cycles long: a 64-element vector operation runs on 16 lanes, one quarter of the elements per cycle, and the block exposes which quarter is active. Back-to-back vector instructions never wait, because a bypass path feeds each result straight into the next vector operation.

One case is not covered by the bypass. The 64-bit per-element condition mask, written by vector comparisons and by the carry-out of vector adds, is not ready for a scalar instruction that reads it in the very next slot. The block records whether the instruction that issued in the previous slot wrote the mask. If the current candidate is a scalar instruction that reads the mask, the block withholds issue for exactly one slot. Any slot that does not issue a mask-writing vector instruction clears the record: a NOP, another instruction kind, an empty slot or the bubble itself. All other hazards are left to the compiler.

Top module: `mask_interlock`

## Requirements
- R1: While rst_ni is low and after it rises, the block starts at lane quarter 0 with no recorded mask producer. issue_o and stall_o are low when no instruction is presented.
- R2: lane_quarter_o counts 0,1,2,3 and wraps, advancing once per clock. A slot begins in each cycle where it is 0.
- R3: issue_o can be high only in a cycle where lane_quarter_o is 0. It is high exactly when inst_valid_i is high and stall_o is low.
- R4: A vector instruction (inst_kind_i = 1) that follows a mask-writing vector instruction issues in the next slot, whatever it reads.
- R5: A scalar instruction (inst_kind_i = 2) with inst_rd_mask_i = 1, presented in the slot right after a vector instruction issued with inst_wr_mask_i = 1, sees stall_o high and issue_o low for one slot. It issues in the slot that follows, and that second attempt does not stall.
- R6: A vector instruction issued with inst_wr_mask_i = 0 never causes a later stall.
- R7: Kind 3 (any other instruction) issues without stalling and clears the producer record. A mask-reading scalar instruction placed after it does not stall.
- R8: A NOP (inst_kind_i = 0) occupies and issues in a slot and clears the producer record.
- R9: A slot with inst_valid_i low clears the producer record.
- R10: A scalar instruction with inst_rd_mask_i = 0 never stalls, even right after a mask writer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inst_valid_i | input | 1 | A decoded instruction is presented; held until issued |
| inst_kind_i | input | 2 | 0 NOP, 1 vector, 2 scalar, 3 other |
| inst_wr_mask_i | input | 1 | Instruction writes the condition mask |
| inst_rd_mask_i | input | 1 | Instruction reads the condition mask |
| issue_o | output | 1 | Presented instruction issues in this slot |
| stall_o | output | 1 | Presented instruction is held one slot for the mask hazard |
| lane_quarter_o | output | 2 | Active lane quarter within the slot |

## Verification
Properties check on every cycle that the phase counter wraps and that issue and stall appear only at a slot start and never together. They also check that a mask-writing vector issue leaves the producer record set, and that a stall always clears it, so no bubble lasts longer than one slot. How many slots an instruction waits under particular orderings can only be shown by the bench's scenarios. These cover a vector consumer, a scalar mask reader, an intervening NOP, another instruction kind or an empty slot, and a non-writing vector producer. A behavioural model compared on every clock covers the rest.

// File: rtl/mask_interlock_pkg.sv
package mask_interlock_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_VALU  = 2'd1,
    OP_SALU  = 2'd2,
    OP_OTHER = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic     valid;
    op_kind_e kind;
    logic     wr_mask;
    logic     rd_mask;
  } inst_desc_t;
endpackage

// File: rtl/slot_phase_timer.sv
module slot_phase_timer #(
  parameter int SLOT_CYCLES = 4,
  localparam int PhW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [PhW-1:0] phase_o,
  output logic           slot_start_o
);
  localparam logic [PhW-1:0] PhLast = PhW'(SLOT_CYCLES - 1);

  logic [PhW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_q <= '0;
    else if (phase_q == PhLast) phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end

  assign phase_o      = phase_q;
  assign slot_start_o = (phase_q == '0);

  p_phase_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PhLast) |=> (phase_q == '0));
  p_phase_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PhLast) |=> (phase_q == $past(phase_q) + 1'b1));
endmodule

// File: rtl/mask_hazard_tracker.sv
module mask_hazard_tracker
  import mask_interlock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slot_start_i,
  input  inst_desc_t desc_i,
  input  logic       issue_i,
  output logic       stall_o,
  output logic       vprod_o
);
  logic vprod_q;

  // Record survives exactly one slot; any non-producing slot clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           vprod_q <= 1'b0;
    else if (slot_start_i) vprod_q <= issue_i && (desc_i.kind == OP_VALU) && desc_i.wr_mask;
  end

  assign stall_o = slot_start_i && desc_i.valid && vprod_q
                && (desc_i.kind == OP_SALU) && desc_i.rd_mask;
  assign vprod_o = vprod_q;

  p_single_bubble_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !vprod_q);
  p_prod_record_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_start_i && issue_i && desc_i.kind == OP_VALU && desc_i.wr_mask) |=> vprod_q);
  p_no_record_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_start_i && !(issue_i && desc_i.kind == OP_VALU && desc_i.wr_mask)) |=> !vprod_q);
endmodule

// File: rtl/mask_interlock.sv
module mask_interlock
  import mask_interlock_pkg::*;
#(
  parameter int WAVE_SIZE = 64,
  parameter int LANES     = 16,
  localparam int SlotCycles = WAVE_SIZE / LANES,
  localparam int PhW        = (SlotCycles > 1) ? $clog2(SlotCycles) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           inst_valid_i,
  input  logic [1:0]     inst_kind_i,
  input  logic           inst_wr_mask_i,
  input  logic           inst_rd_mask_i,
  output logic           issue_o,
  output logic           stall_o,
  output logic [PhW-1:0] lane_quarter_o
);
  inst_desc_t desc;
  logic       slot_start;
  logic       stall;
  logic       vprod;

  assign desc.valid   = inst_valid_i;
  assign desc.kind    = op_kind_e'(inst_kind_i);
  assign desc.wr_mask = inst_wr_mask_i;
  assign desc.rd_mask = inst_rd_mask_i;

  slot_phase_timer #(.SLOT_CYCLES(SlotCycles)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_o      (lane_quarter_o),
    .slot_start_o (slot_start)
  );

  mask_hazard_tracker u_tracker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_start_i (slot_start),
    .desc_i       (desc),
    .issue_i      (issue_o),
    .stall_o      (stall),
    .vprod_o      (vprod)
  );

  assign issue_o = slot_start && inst_valid_i && !stall;
  assign stall_o = stall;

  p_issue_at_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (lane_quarter_o == '0));
  p_stall_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!issue_o && lane_quarter_o == '0 && vprod));
  p_salu_free_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_kind_i != 2'd2 || !inst_rd_mask_i) |-> !stall_o);
endmodule

// File: tb/mask_interlock_test.sv
`timescale 1ns/1ps
module mask_interlock_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid = 1'b0;
  logic [1:0] kind = 2'd0;
  logic       wr = 1'b0, rd = 1'b0;
  logic       issue_o, stall_o;
  logic [1:0] lane_quarter_o;

  int n_cmp = 0, n_bad = 0;
  int m_phase = 0;
  bit m_prod = 0;

  always #4 clk = ~clk;

  mask_interlock uut (
    .clk_i(clk), .rst_ni(rst_ni), .inst_valid_i(valid), .inst_kind_i(kind),
    .inst_wr_mask_i(wr), .inst_rd_mask_i(rd),
    .issue_o(issue_o), .stall_o(stall_o), .lane_quarter_o(lane_quarter_o)
  );

  function automatic bit m_stall();
    return (m_phase == 0) && valid && m_prod && kind == 2'd2 && rd;
  endfunction
  function automatic bit m_issue();
    return (m_phase == 0) && valid && !m_stall();
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_phase = 0; m_prod = 0;
    end else begin
      if (m_phase == 0) m_prod = m_issue() && kind == 2'd1 && wr;
      m_phase = (m_phase + 1) % 4;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check("R2 lane quarter", lane_quarter_o, m_phase);
    check("R3 issue", issue_o, m_issue());
    check("R5 stall", stall_o, m_stall());
  end

  task automatic send(input logic [1:0] k, input logic w, input logic r, output int stalls);
    bit done = 0;
    int guard = 0;
    stalls = 0;
    valid = 1'b1; kind = k; wr = w; rd = r;
    while (!done && guard < 40) begin
      @(negedge clk);
      if (stall_o) stalls++;
      if (issue_o) done = 1;
      @(posedge clk); #1;
      guard++;
    end
    if (!done) check("watchdog", 0, 1);
    valid = 1'b0;
  endtask

  task automatic idle_slot();
    do @(negedge clk); while (lane_quarter_o != 2'd0);
    @(posedge clk); #1;
  endtask

  initial begin
    int s;
    #20;
    @(negedge clk);
    check("R1 reset quarter", lane_quarter_o, 0);
    check("R1 reset issue", issue_o, 0);
    check("R1 reset stall", stall_o, 0);
    @(posedge clk); #1; rst_ni = 1'b1;
    idle_slot();
    check("R1 first quarter after reset", lane_quarter_o, 1);
    idle_slot();
    // R4 dependent vector pair
    send(2'd1, 1, 0, s); send(2'd1, 0, 1, s); check("R4 vector after mask writer", s, 0);
    // R5 scalar mask reader right after mask writer
    send(2'd1, 1, 0, s); send(2'd2, 0, 1, s); check("R5 one bubble", s, 1);
    send(2'd2, 0, 1, s); check("R5 second reader no stall", s, 0);
    // R6 non-writing vector
    send(2'd1, 0, 0, s); send(2'd2, 0, 1, s); check("R6 no writer no stall", s, 0);
    // R7 other kind in between
    send(2'd1, 1, 0, s); send(2'd3, 0, 0, s); check("R7 other kind issues", s, 0);
    send(2'd2, 0, 1, s); check("R7 reader after other", s, 0);
    // R8 NOP in between
    send(2'd1, 1, 0, s); send(2'd0, 0, 0, s); check("R8 nop issues", s, 0);
    send(2'd2, 0, 1, s); check("R8 reader after nop", s, 0);
    // R9 empty slot in between
    send(2'd1, 1, 0, s); idle_slot(); send(2'd2, 0, 1, s); check("R9 reader after empty slot", s, 0);
    // R10 scalar not reading mask
    send(2'd1, 1, 0, s); send(2'd2, 1, 0, s); check("R10 non-reader scalar", s, 0);
    // R5 again after vector pair chain
    send(2'd1, 1, 1, s); send(2'd1, 1, 1, s); send(2'd2, 0, 1, s); check("R5 after chained writers", s, 1);
    repeat (8) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule